// File: doc/BRIEF.md
# Interrupt Destination Address Matcher

This block decides, in the same cycle, whether the local processor's interrupt controller is addressed by an incoming inter-processor or routed interrupt. It takes a destination value, a physical/logical mode bit, a two-bit shorthand and a flag that says the sender is this same controller. From these it drives one match bit.

It also keeps the three registers that addressing depends on: the local identity, the logical destination and the destination format. Each has its own write masking. In extended addressing mode the identity, logical and format registers are locked against writes. The logical register is then replaced by a value derived from the identity: a cluster number plus a one-hot member bit. The destination is also widened to 32 bits in that mode.

Top module: `irq_dest_match`

## Requirements
- R1: Shorthand 1 (self only) matches exactly when `src_self_i` is high, whatever the destination and mode.
- R2: Shorthand 2 (all including self) always matches.
- R3: Shorthand 3 (all excluding self) matches exactly when `src_self_i` is low.
- R4: With shorthand 0 and `logical_i` low, the block matches when the destination equals 0xFF or equals the 8-bit identity held in bits [31:24] of the identity register. Outside extended mode only `dest_i[7:0]` is compared. In extended mode all 32 bits are compared against the zero-extended identity.
- R5: With shorthand 0, `logical_i` high, and format bits [31:28] equal to 0xF (flat), the block matches when the logical ID in bits [31:24] of the logical register ANDed with `dest_i[7:0]` is non-zero.
- R6: With format bits [31:28] equal to 0x0 (cluster), the block matches when the upper nibbles of the logical ID and `dest_i[7:0]` are equal and the AND of their lower nibbles is non-zero.
- R7: A write to the format register stores the written data with bits [27:0] forced to one. Any value of bits [31:28] other than 0xF or 0x0 gives no logical match.
- R8: A write to the logical register keeps bits [31:24] and clears bits [23:0].
- R9: In extended mode the logical register reads as {8'h00, id[7:4], 4'h0, one-hot of id[3:0] over 16 bits}. A logical match is then that value ANDed with the full 32-bit destination being non-zero.
- R10: Register select 0 is identity, 1 is logical and 2 is format. A write with select 3, or any write while in extended mode, changes no register and raises `wr_err_o` in the same cycle.
- R11: After reset the identity register holds CPU_NUM in bits [31:24] and zero elsewhere. The logical register is zero and the format register is 0xFFFFFFFF.
- R12: A write to the identity register outside extended mode stores all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | Extended addressing mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 identity, 1 logical, 2 format, 3 reserved |
| wr_data_i | input | 32 | Write data |
| wr_err_o | output | 1 | Write rejected this cycle |
| dest_i | input | 32 | Destination value |
| logical_i | input | 1 | 1 = logical destination, 0 = physical |
| shorthand_i | input | 2 | 0 destination, 1 self, 2 all incl. self, 3 all excl. self |
| src_self_i | input | 1 | Sender is this controller |
| match_o | output | 1 | This controller is a target |
| id_reg_o | output | 32 | Identity register |
| log_reg_o | output | 32 | Effective logical register |
| fmt_reg_o | output | 32 | Format register |

## Verification
On every cycle, the assertions check the three shorthand rules against the match output. They also check that the derived logical value has exactly one member bit in extended mode, and that a write issued in extended mode leaves all three registers untouched. Only the bench scenarios can show the address comparisons themselves. These are the physical equality and broadcast, flat and cluster overlap, and rejection of an unknown format. The write masking of each register and the extended-mode derivation for a particular identity are likewise shown only by the scenarios.

// File: rtl/irq_dm_pkg.sv
package irq_dm_pkg;
  localparam int REG_W  = 32;
  localparam int ID_W   = 8;
  localparam int NIB_W  = ID_W / 2;
  localparam int MEM_W  = 1 << NIB_W;

  typedef enum logic [1:0] {
    SH_DEST    = 2'd0,
    SH_SELF    = 2'd1,
    SH_ALL_INC = 2'd2,
    SH_ALL_EXC = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    SEL_ID   = 2'd0,
    SEL_LOG  = 2'd1,
    SEL_FMT  = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [REG_W-1:0] FMT_FORCE = 32'h0FFF_FFFF;
endpackage

// File: rtl/irq_dm_regs.sv
module irq_dm_regs
  import irq_dm_pkg::*;
#(
  parameter int CPU_NUM = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             wr_err_o,
  output logic [REG_W-1:0] id_reg_o,
  output logic [REG_W-1:0] log_reg_o,
  output logic [REG_W-1:0] fmt_reg_o
);
  localparam logic [ID_W-1:0] RST_ID = ID_W'(CPU_NUM);

  logic [REG_W-1:0] id_q, log_q, fmt_q;
  logic [ID_W-1:0]  id8;
  logic [MEM_W-1:0] member;
  logic             wr_ok;

  assign wr_ok    = wr_en_i && !ext_mode_i && (reg_sel_e'(wr_sel_i) != SEL_RSVD);
  assign wr_err_o = wr_en_i && !wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= {RST_ID, {(REG_W-ID_W){1'b0}}};
      log_q <= '0;
      fmt_q <= '1;
    end else if (wr_ok) begin
      unique case (reg_sel_e'(wr_sel_i))
        SEL_ID:  id_q  <= wr_data_i;
        SEL_LOG: log_q <= {wr_data_i[REG_W-1 -: ID_W], {(REG_W-ID_W){1'b0}}};
        SEL_FMT: fmt_q <= wr_data_i | FMT_FORCE;
        default: ;
      endcase
    end
  end

  assign id8 = id_q[REG_W-1 -: ID_W];

  always_comb begin
    for (int i = 0; i < MEM_W; i++) member[i] = (id8[NIB_W-1:0] == NIB_W'(i));
  end

  // extended mode: cluster in [23:20], one-hot member in [15:0]
  assign log_reg_o = ext_mode_i ? {8'h00, id8[ID_W-1:NIB_W], 4'h0, member} : log_q;
  assign id_reg_o  = id_q;
  assign fmt_reg_o = fmt_q;

  // R10
  ext_wr_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ext_mode_i) |=> ($stable(id_q) && $stable(log_q) && $stable(fmt_q)));

  // R9
  ext_member_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_mode_i |-> $onehot(log_reg_o[MEM_W-1:0]));
endmodule

// File: rtl/irq_dm_phys_match.sv
module irq_dm_phys_match
  import irq_dm_pkg::*;
(
  input  logic             ext_mode_i,
  input  logic [REG_W-1:0] id_reg_i,
  input  logic [REG_W-1:0] dest_i,
  output logic             hit_o
);
  logic [ID_W-1:0]  id8;
  logic [REG_W-1:0] cmp;

  assign id8   = id_reg_i[REG_W-1 -: ID_W];
  assign cmp   = ext_mode_i ? dest_i : {{(REG_W-ID_W){1'b0}}, dest_i[ID_W-1:0]};
  assign hit_o = (cmp == REG_W'(8'hFF)) || (cmp == {{(REG_W-ID_W){1'b0}}, id8});
endmodule

// File: rtl/irq_dm_logical_match.sv
module irq_dm_logical_match
  import irq_dm_pkg::*;
(
  input  logic             ext_mode_i,
  input  logic [REG_W-1:0] log_reg_i,
  input  logic [REG_W-1:0] fmt_reg_i,
  input  logic [REG_W-1:0] dest_i,
  output logic             hit_o
);
  logic [ID_W-1:0] lid, md;
  logic            flat_hit, clus_hit;

  assign lid = log_reg_i[REG_W-1 -: ID_W];
  assign md  = dest_i[ID_W-1:0];

  assign flat_hit = |(lid & md);
  assign clus_hit = (lid[ID_W-1:NIB_W] == md[ID_W-1:NIB_W]) &&
                    |(lid[NIB_W-1:0] & md[NIB_W-1:0]);

  always_comb begin
    if (ext_mode_i) hit_o = |(log_reg_i & dest_i);
    else begin
      unique case (fmt_reg_i[REG_W-1 -: 4])
        FMT_FLAT:    hit_o = flat_hit;
        FMT_CLUSTER: hit_o = clus_hit;
        default:     hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
  import irq_dm_pkg::*;
#(
  parameter int CPU_NUM = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ext_mode_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  output logic        wr_err_o,
  input  logic [31:0] dest_i,
  input  logic        logical_i,
  input  logic [1:0]  shorthand_i,
  input  logic        src_self_i,
  output logic        match_o,
  output logic [31:0] id_reg_o,
  output logic [31:0] log_reg_o,
  output logic [31:0] fmt_reg_o
);
  logic phys_hit, log_hit;

  irq_dm_regs #(.CPU_NUM(CPU_NUM)) u_regs (
    .clk_i, .rst_ni, .ext_mode_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .wr_err_o, .id_reg_o, .log_reg_o, .fmt_reg_o
  );

  irq_dm_phys_match u_phys (
    .ext_mode_i, .id_reg_i(id_reg_o), .dest_i, .hit_o(phys_hit)
  );

  irq_dm_logical_match u_log (
    .ext_mode_i, .log_reg_i(log_reg_o), .fmt_reg_i(fmt_reg_o), .dest_i, .hit_o(log_hit)
  );

  always_comb begin
    unique case (shorthand_e'(shorthand_i))
      SH_DEST:    match_o = logical_i ? log_hit : phys_hit;
      SH_SELF:    match_o = src_self_i;
      SH_ALL_INC: match_o = 1'b1;
      SH_ALL_EXC: match_o = !src_self_i;
      default:    match_o = 1'b0;
    endcase
  end

  // R1
  self_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shorthand_i == 2'd1 && !src_self_i) |-> !match_o);

  // R2
  all_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shorthand_i == 2'd2) |-> match_o);

  // R3
  all_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shorthand_i == 2'd3 && src_self_i) |-> !match_o);
endmodule

// File: tb/irq_dest_match_tb.sv
module irq_dest_match_tb;
  localparam int CPU_NUM = 5;

  logic        clk = 0, rst_ni = 0;
  logic        ext_mode = 0, wr_en = 0, logical = 0, src_self = 0;
  logic [1:0]  wr_sel = 0, shorthand = 0;
  logic [31:0] wr_data = 0, dest = 0;
  logic        wr_err, match;
  logic [31:0] id_reg, log_reg, fmt_reg;

  int applied = 0, fails = 0;

  always #10 clk = ~clk;

  irq_dest_match #(.CPU_NUM(CPU_NUM)) u_dut (
    .clk_i(clk), .rst_ni, .ext_mode_i(ext_mode), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .wr_err_o(wr_err), .dest_i(dest), .logical_i(logical),
    .shorthand_i(shorthand), .src_self_i(src_self), .match_o(match),
    .id_reg_o(id_reg), .log_reg_o(log_reg), .fmt_reg_o(fmt_reg)
  );

  typedef struct {
    bit          chk_match;
    bit          exp_match;
    bit          chk_regs;
    logic [31:0] exp_id, exp_log, exp_fmt;
    bit          exp_err;
    string       tag;
  } item_t;

  item_t q[$];

  task automatic chk_match(input logic [1:0] sh, input logic lg, input logic self,
                           input logic [31:0] d, input bit exp, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 0; shorthand = sh; logical = lg; src_self = self; dest = d;
    it = '{chk_match:1, exp_match:exp, chk_regs:0, exp_id:0, exp_log:0, exp_fmt:0,
           exp_err:0, tag:tag};
    q.push_back(it);
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [31:0] data,
                          input bit exp_err, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = data;
    it = '{chk_match:0, exp_match:0, chk_regs:0, exp_id:0, exp_log:0, exp_fmt:0,
           exp_err:exp_err, tag:tag};
    q.push_back(it);
  endtask

  task automatic chk_regs(input logic [31:0] eid, input logic [31:0] elog,
                          input logic [31:0] efmt, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 0;
    it = '{chk_match:0, exp_match:0, chk_regs:1, exp_id:eid, exp_log:elog, exp_fmt:efmt,
           exp_err:0, tag:tag};
    q.push_back(it);
  endtask

  task automatic set_ext(input logic v);
    @(negedge clk);
    wr_en = 0; ext_mode = v;
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        applied++;
        if (wr_err !== it.exp_err) begin
          fails++;
          $display("FAIL %s wr_err actual=%0b expected=%0b", it.tag, wr_err, it.exp_err);
        end
        if (it.chk_match && match !== it.exp_match) begin
          fails++;
          $display("FAIL %s match actual=%0b expected=%0b", it.tag, match, it.exp_match);
        end
        if (it.chk_regs && (id_reg !== it.exp_id || log_reg !== it.exp_log ||
                            fmt_reg !== it.exp_fmt)) begin
          fails++;
          $display("FAIL %s regs actual=%h/%h/%h expected=%h/%h/%h", it.tag,
                   id_reg, log_reg, fmt_reg, it.exp_id, it.exp_log, it.exp_fmt);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R11 reset state
    chk_regs(32'h0500_0000, 32'h0, 32'hFFFF_FFFF, "R11 reset");
    // R4 physical
    chk_match(2'd0, 0, 0, 32'h05, 1, "R4 own id");
    chk_match(2'd0, 0, 0, 32'h06, 0, "R4 other id");
    chk_match(2'd0, 0, 0, 32'hFF, 1, "R4 broadcast");
    chk_match(2'd0, 0, 0, 32'h0000_0105, 1, "R4 upper bits ignored");
    // R12 id write
    do_write(2'd0, 32'h2A00_1234, 0, "R12 id write");
    chk_regs(32'h2A00_1234, 32'h0, 32'hFFFF_FFFF, "R12 id stored");
    chk_match(2'd0, 0, 0, 32'h2A, 1, "R4 new id");
    chk_match(2'd0, 0, 0, 32'h05, 0, "R4 old id");
    // R8 logical write
    do_write(2'd1, 32'h1234_5678, 0, "R8 log write");
    chk_regs(32'h2A00_1234, 32'h1200_0000, 32'hFFFF_FFFF, "R8 log masked");
    // R5 flat
    chk_match(2'd0, 1, 0, 32'h02, 1, "R5 flat overlap");
    chk_match(2'd0, 1, 0, 32'h01, 0, "R5 flat no overlap");
    chk_match(2'd0, 1, 0, 32'hED, 0, "R5 flat complement");
    // R7 format write then R6 cluster
    do_write(2'd2, 32'h0000_0000, 0, "R7 fmt write");
    chk_regs(32'h2A00_1234, 32'h1200_0000, 32'h0FFF_FFFF, "R7 fmt forced");
    chk_match(2'd0, 1, 0, 32'h13, 1, "R6 cluster hit");
    chk_match(2'd0, 1, 0, 32'h22, 0, "R6 cluster mismatch");
    chk_match(2'd0, 1, 0, 32'h11, 0, "R6 member no overlap");
    do_write(2'd2, 32'h5000_0000, 0, "R7 bad fmt write");
    chk_regs(32'h2A00_1234, 32'h1200_0000, 32'h5FFF_FFFF, "R7 bad fmt stored");
    chk_match(2'd0, 1, 0, 32'h13, 0, "R7 bad fmt no match");
    chk_match(2'd0, 1, 0, 32'hFF, 0, "R7 bad fmt no match ff");
    // shorthands
    chk_match(2'd1, 0, 1, 32'h00, 1, "R1 self");
    chk_match(2'd1, 0, 0, 32'h2A, 0, "R1 not self");
    chk_match(2'd2, 0, 0, 32'h00, 1, "R2 all inc");
    chk_match(2'd2, 1, 1, 32'h00, 1, "R2 all inc self");
    chk_match(2'd3, 0, 1, 32'h2A, 0, "R3 all exc self");
    chk_match(2'd3, 0, 0, 32'h00, 1, "R3 all exc other");
    // R10 reserved select
    do_write(2'd3, 32'hDEAD_BEEF, 1, "R10 rsvd sel");
    chk_regs(32'h2A00_1234, 32'h1200_0000, 32'h5FFF_FFFF, "R10 rsvd no change");
    // extended mode
    set_ext(1);
    chk_regs(32'h2A00_1234, 32'h0020_0400, 32'h5FFF_FFFF, "R9 derived log");
    chk_match(2'd0, 1, 0, 32'h0000_0400, 1, "R9 member hit");
    chk_match(2'd0, 1, 0, 32'h0010_0000, 0, "R9 no overlap");
    chk_match(2'd0, 1, 0, 32'h0020_0000, 1, "R9 cluster bit hit");
    chk_match(2'd0, 0, 0, 32'h2A, 1, "R4 ext id");
    chk_match(2'd0, 0, 0, 32'h0000_012A, 0, "R4 ext wide mismatch");
    chk_match(2'd0, 0, 0, 32'hFF, 1, "R4 ext broadcast");
    do_write(2'd0, 32'h7700_0000, 1, "R10 ext id write");
    do_write(2'd2, 32'hF000_0000, 1, "R10 ext fmt write");
    do_write(2'd1, 32'hFF00_0000, 1, "R10 ext log write");
    chk_regs(32'h2A00_1234, 32'h0020_0400, 32'h5FFF_FFFF, "R10 ext locked");
    set_ext(0);
    chk_regs(32'h2A00_1234, 32'h1200_0000, 32'h5FFF_FFFF, "R9 leave ext");
    wait (q.size() == 0);
    @(posedge clk);
    #5;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule